// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block carries out in-band software flow control for a single asynchronous serial channel. It works in both directions. On the receive side, each character that arrives from the deserializer is compared with four programmed flow characters. Two 2-bit mode fields select single-character or paired sequential recognition. A recognised Xoff stops the local transmitter and raises an interrupt flag. A recognised Xon releases the transmitter. Every other character is passed on as a write to the receive FIFO.

On the transmit side, the block watches the receive FIFO fill level against a halt threshold and a resume threshold. It asks the transmitter to inject Xoff or Xon characters. It remembers which scheme was in force when the Xoff went out, so that a later mode change still releases the far end with the right Xon.

The transmitter stays outside the block. It reports whether a character is on the wire (`tx_busy`), takes injected characters through `inj_req`/`inj_ack`, and may start a FIFO byte only while `tx_data_en` is high. The serializer, the FIFOs and the host bus are also outside the block.

Top module: `xonxoff_ctrl`

## Requirements
- R1: `tx_mode` picks the injected characters: 2'b10 uses Xon1/Xoff1, 2'b01 uses Xon2/Xoff2, 2'b11 sends Xoff1 then Xoff2 (and Xon1 then Xon2), and 2'b00 injects nothing new.
- R2: An Xoff injection starts when `rx_level` exceeds `halt_thr`×4. The matching Xon injection starts once `rx_level` is at or below `resume_thr`×4. Each starts at most once per crossing.
- R3: `inj_req` stays high with a stable character until `inj_ack`. In paired mode the second character follows only after the first is acknowledged. `tx_data_en` is low while `inj_req` is high.
- R4: `inj_char` is masked to the word length in effect: `word_len` 2'b00/01/10/11 keeps the low 5/6/7/8 bits.
- R5: If `tx_mode` changes while an Xoff is outstanding, or goes to 2'b00, the Xon of the scheme that sent the Xoff is injected first. If the level is still above the halt threshold and the new mode is not 2'b00, the new scheme's Xoff follows.
- R6: With `rx_mode` 2'b10 (Xon1/Xoff1) or 2'b01 (Xon2/Xoff2), an error-free matching Xoff sets the halt request and `xoff_irq`. A matching Xon clears both. Neither character is written to the FIFO.
- R7: With `rx_mode` 2'b11, only Xon1 followed by Xon2, or Xoff1 followed by Xoff2, acts as flow control and is discarded. A held first character that is not completed is written to the FIFO, and the next character is then handled on its own, one cycle later.
- R8: A character with any bit of `rx_err` set is written as ordinary data and never acts as a flow character.
- R9: With `xon_any` set while halted, any received character releases the halt and clears `xoff_irq`. It is written to the FIFO unless it is the scheme's (first) Xon character.
- R10: With `special_en` set, an error-free Xoff2 that is not consumed as a flow character sets `xoff_irq`, is written to the FIFO and does not halt.
- R11: `tx_halt` changes only in cycles where `tx_busy` is low, so a character already on the wire completes.
- R12: `irq_clr` clears `xoff_irq`. With `rx_mode` 2'b00 every character is written and the halt request is released.
- R13: After reset, `tx_halt`, `inj_req`, `rx_wr_en` and `xoff_irq` are low and `tx_data_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_char | input | CHAR_W | Received character |
| rx_err | input | ERR_W | Parity, framing and break flags for rx_char |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_busy | input | 1 | Transmitter is sending a character |
| inj_ack | input | 1 | Transmitter has taken inj_char |
| tx_mode | input | 2 | Transmit flow scheme |
| rx_mode | input | 2 | Receive compare scheme |
| xon_any | input | 1 | Any character resumes transmission |
| special_en | input | 1 | Xoff2 acts as a special interrupt character |
| irq_clr | input | 1 | Host acknowledge of xoff_irq |
| halt_thr | input | THR_W | Halt threshold in units of 4 |
| resume_thr | input | THR_W | Resume threshold in units of 4 |
| word_len | input | 2 | Character length code, 5 to 8 bits |
| xon1 | input | CHAR_W | First Xon character |
| xon2 | input | CHAR_W | Second Xon character |
| xoff1 | input | CHAR_W | First Xoff character |
| xoff2 | input | CHAR_W | Second Xoff character |
| tx_halt | output | 1 | Transmitter stopped by a received Xoff |
| tx_data_en | output | 1 | Transmitter may start the next FIFO byte |
| inj_req | output | 1 | A flow character is waiting to be sent |
| inj_char | output | CHAR_W | Flow character to send |
| rx_wr_en | output | 1 | Write strobe for the receive FIFO |
| rx_wr_char | output | CHAR_W | Character to write |
| xoff_irq | output | 1 | Xoff or special-character interrupt flag |

## Verification
The checker assumes that `rx_valid` never occurs in two consecutive cycles. That spacing leaves room for the extra write that a broken sequential pair produces. The checker also assumes that `inj_ack` arrives only while `inj_req` is high. The bench sends each received character as a single-cycle strobe followed by at least three idle cycles, and raises `inj_ack` only after it has seen `inj_req`. Under those conditions, random character streams drawn mostly from the four flow characters exercise every receive scheme, the error flags, Xon-any and the special character. A bench model predicts the writes, halt and flag for each character.

// File: rtl/xonxoff_pkg.sv
package xonxoff_pkg;

    localparam logic [1:0] FC_OFF  = 2'b00;
    localparam logic [1:0] FC_SET2 = 2'b01;
    localparam logic [1:0] FC_SET1 = 2'b10;
    localparam logic [1:0] FC_PAIR = 2'b11;

    typedef enum logic [1:0] {
        INJ_IDLE   = 2'd0,
        INJ_FIRST  = 2'd1,
        INJ_SECOND = 2'd2
    } inj_state_e;

    typedef enum logic {
        KIND_XON  = 1'b0,
        KIND_XOFF = 1'b1
    } flow_kind_e;

endpackage

// File: rtl/xonxoff_rx_match.sv
module xonxoff_rx_match
    import xonxoff_pkg::*;
#(
    parameter int CHAR_W = 8,
    parameter int ERR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic [1:0]        rx_mode,
    input  logic              xon_any,
    input  logic              special_en,
    input  logic              irq_clr,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    output logic              wr_en,
    output logic [CHAR_W-1:0] wr_char,
    output logic              halt_req,
    output logic              flag
);

    typedef struct packed {
        logic              wr_en;
        logic [CHAR_W-1:0] wr_char;
        logic              pend_v;
        logic [CHAR_W-1:0] pend_char;
        logic              held_v;
        flow_kind_e        held_kind;
        logic [CHAR_W-1:0] held_char;
        logic              halt;
        logic              flag;
    } rx_state_t;

    rx_state_t st_q, st_d;

    logic              clean;
    logic              seq_mode;
    logic              single_mode;
    logic [CHAR_W-1:0] xon_sel;
    logic [CHAR_W-1:0] xoff_sel;
    logic [CHAR_W-1:0] first_xon;
    logic              consumed;
    logic              slot_used;
    logic              fresh_wr;
    logic              xon_hit;
    logic              xoff_hit;
    logic              spec_hit;
    logic              resume_hit;

    always_comb begin
        clean       = (rx_err == '0) && (rx_mode != FC_OFF);
        seq_mode    = (rx_mode == FC_PAIR);
        single_mode = (rx_mode == FC_SET1) || (rx_mode == FC_SET2);
        xon_sel     = (rx_mode == FC_SET2) ? xon2 : xon1;
        xoff_sel    = (rx_mode == FC_SET2) ? xoff2 : xoff1;
        first_xon   = seq_mode ? xon1 : xon_sel;

        st_d       = st_q;
        st_d.wr_en = 1'b0;
        consumed   = 1'b0;
        slot_used  = 1'b0;
        fresh_wr   = 1'b0;
        xon_hit    = 1'b0;
        xoff_hit   = 1'b0;
        spec_hit   = 1'b0;
        resume_hit = 1'b0;

        if (st_q.pend_v) begin
            st_d.wr_en   = 1'b1;
            st_d.wr_char = st_q.pend_char;
            st_d.pend_v  = 1'b0;
        end

        if (rx_valid) begin
            if (st_q.held_v) begin
                st_d.held_v = 1'b0;
                if (clean && st_q.held_kind == KIND_XON && rx_char == xon2) begin
                    consumed = 1'b1;
                    xon_hit  = 1'b1;
                end else if (clean && st_q.held_kind == KIND_XOFF && rx_char == xoff2) begin
                    consumed = 1'b1;
                    xoff_hit = 1'b1;
                end else begin
                    st_d.wr_en   = 1'b1;
                    st_d.wr_char = st_q.held_char;
                    slot_used    = 1'b1;
                end
            end

            if (!consumed) begin
                if (xon_any && st_q.halt) begin
                    resume_hit = 1'b1;
                    fresh_wr   = !(clean && rx_char == first_xon);
                end else if (seq_mode && clean && rx_char == xon1) begin
                    st_d.held_v    = 1'b1;
                    st_d.held_kind = KIND_XON;
                    st_d.held_char = rx_char;
                end else if (seq_mode && clean && rx_char == xoff1) begin
                    st_d.held_v    = 1'b1;
                    st_d.held_kind = KIND_XOFF;
                    st_d.held_char = rx_char;
                end else if (single_mode && clean && rx_char == xon_sel) begin
                    xon_hit = 1'b1;
                end else if (single_mode && clean && rx_char == xoff_sel) begin
                    xoff_hit = 1'b1;
                end else begin
                    fresh_wr = 1'b1;
                    spec_hit = special_en && (rx_err == '0) && (rx_char == xoff2);
                end

                if (fresh_wr) begin
                    if (slot_used) begin
                        st_d.pend_v    = 1'b1;
                        st_d.pend_char = rx_char;
                    end else begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_char = rx_char;
                    end
                end
            end
        end

        if (xoff_hit || spec_hit) begin
            st_d.flag = 1'b1;
        end else if (xon_hit || resume_hit || irq_clr) begin
            st_d.flag = 1'b0;
        end

        if (xoff_hit) begin
            st_d.halt = 1'b1;
        end else if (xon_hit || resume_hit || rx_mode == FC_OFF) begin
            st_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en    = st_q.wr_en;
    assign wr_char  = st_q.wr_char;
    assign halt_req = st_q.halt;
    assign flag     = st_q.flag;

endmodule

// File: rtl/xonxoff_inject.sv
module xonxoff_inject
    import xonxoff_pkg::*;
#(
    parameter int CHAR_W    = 8,
    parameter int LVL_W     = 7,
    parameter int THR_W     = 4,
    parameter int THR_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        tx_mode,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [THR_W-1:0]  halt_thr,
    input  logic [THR_W-1:0]  resume_thr,
    input  logic              inj_ack,
    input  logic [1:0]        word_len,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    output logic              inj_req,
    output logic [CHAR_W-1:0] inj_char
);

    localparam int MIN_BITS = 5;

    typedef struct packed {
        inj_state_e st;
        flow_kind_e kind;
        logic [1:0] seq_mode;
        logic       xoff_sent;
        logic [1:0] sent_mode;
    } inj_t;

    inj_t q, d;

    logic [LVL_W-1:0]  halt_lvl;
    logic [LVL_W-1:0]  resume_lvl;
    logic              above;
    logic              low;
    logic [CHAR_W-1:0] raw_char;
    logic [CHAR_W-1:0] keep_mask;
    logic              use_second;

    always_comb begin
        halt_lvl   = LVL_W'(halt_thr) << THR_SHIFT;
        resume_lvl = LVL_W'(resume_thr) << THR_SHIFT;
        above      = rx_level > halt_lvl;
        low        = rx_level <= resume_lvl;

        d = q;
        unique case (q.st)
            INJ_IDLE: begin
                if (q.xoff_sent && (low || tx_mode != q.sent_mode)) begin
                    d.st        = INJ_FIRST;
                    d.kind      = KIND_XON;
                    d.seq_mode  = q.sent_mode;
                    d.xoff_sent = 1'b0;
                end else if (!q.xoff_sent && tx_mode != FC_OFF && above) begin
                    d.st        = INJ_FIRST;
                    d.kind      = KIND_XOFF;
                    d.seq_mode  = tx_mode;
                    d.xoff_sent = 1'b1;
                    d.sent_mode = tx_mode;
                end
            end
            INJ_FIRST: begin
                if (inj_ack) begin
                    d.st = (q.seq_mode == FC_PAIR) ? INJ_SECOND : INJ_IDLE;
                end
            end
            INJ_SECOND: begin
                if (inj_ack) begin
                    d.st = INJ_IDLE;
                end
            end
            default: d.st = INJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        use_second = (q.st == INJ_SECOND) || (q.seq_mode == FC_SET2);
        if (q.kind == KIND_XON) begin
            raw_char = use_second ? xon2 : xon1;
        end else begin
            raw_char = use_second ? xoff2 : xoff1;
        end
        keep_mask = ~({CHAR_W{1'b1}} << (MIN_BITS + int'(word_len)));
    end

    assign inj_req  = (q.st != INJ_IDLE);
    assign inj_char = raw_char & keep_mask;

endmodule

// File: rtl/xonxoff_tx_gate.sv
module xonxoff_tx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_busy,
    input  logic halt_req,
    input  logic inj_req,
    output logic tx_halt,
    output logic tx_data_en
);

    typedef struct packed {
        logic halt;
    } gate_t;

    gate_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        if (!tx_busy) begin
            g_d.halt = halt_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign tx_halt    = g_q.halt;
    assign tx_data_en = !g_q.halt && !inj_req;

endmodule

// File: rtl/xonxoff_ctrl.sv
module xonxoff_ctrl #(
    parameter int CHAR_W    = 8,
    parameter int ERR_W     = 3,
    parameter int LVL_W     = 7,
    parameter int THR_W     = 4,
    parameter int THR_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_busy,
    input  logic              inj_ack,
    input  logic [1:0]        tx_mode,
    input  logic [1:0]        rx_mode,
    input  logic              xon_any,
    input  logic              special_en,
    input  logic              irq_clr,
    input  logic [THR_W-1:0]  halt_thr,
    input  logic [THR_W-1:0]  resume_thr,
    input  logic [1:0]        word_len,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    output logic              tx_halt,
    output logic              tx_data_en,
    output logic              inj_req,
    output logic [CHAR_W-1:0] inj_char,
    output logic              rx_wr_en,
    output logic [CHAR_W-1:0] rx_wr_char,
    output logic              xoff_irq
);

    logic halt_req;

    xonxoff_rx_match #(
        .CHAR_W (CHAR_W),
        .ERR_W  (ERR_W)
    ) u_rx_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_char    (rx_char),
        .rx_err     (rx_err),
        .rx_mode    (rx_mode),
        .xon_any    (xon_any),
        .special_en (special_en),
        .irq_clr    (irq_clr),
        .xon1       (xon1),
        .xon2       (xon2),
        .xoff1      (xoff1),
        .xoff2      (xoff2),
        .wr_en      (rx_wr_en),
        .wr_char    (rx_wr_char),
        .halt_req   (halt_req),
        .flag       (xoff_irq)
    );

    xonxoff_inject #(
        .CHAR_W    (CHAR_W),
        .LVL_W     (LVL_W),
        .THR_W     (THR_W),
        .THR_SHIFT (THR_SHIFT)
    ) u_inject (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_mode    (tx_mode),
        .rx_level   (rx_level),
        .halt_thr   (halt_thr),
        .resume_thr (resume_thr),
        .inj_ack    (inj_ack),
        .word_len   (word_len),
        .xon1       (xon1),
        .xon2       (xon2),
        .xoff1      (xoff1),
        .xoff2      (xoff2),
        .inj_req    (inj_req),
        .inj_char   (inj_char)
    );

    xonxoff_tx_gate u_tx_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_busy    (tx_busy),
        .halt_req   (halt_req),
        .inj_req    (inj_req),
        .tx_halt    (tx_halt),
        .tx_data_en (tx_data_en)
    );

endmodule

// File: rtl/xonxoff_ctrl_chk.sv
module xonxoff_ctrl_chk #(
    parameter int CHAR_W = 8,
    parameter int ERR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_char,
    input logic [ERR_W-1:0]  rx_err,
    input logic              tx_busy,
    input logic              inj_ack,
    input logic [1:0]        rx_mode,
    input logic              xon_any,
    input logic [1:0]        word_len,
    input logic [CHAR_W-1:0] xon1,
    input logic [CHAR_W-1:0] xoff1,
    input logic              tx_halt,
    input logic              inj_req,
    input logic [CHAR_W-1:0] inj_char,
    input logic              rx_wr_en,
    input logic              xoff_irq
);

    // R3: a pending flow character is held until the transmitter takes it
    p_inj_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_req && !inj_ack) |=> inj_req);

    // R3: the offered character does not change while unacknowledged
    p_inj_char_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_req && !inj_ack) |=> $stable(inj_char));

    // R4: five-bit words leave the upper bits clear
    p_mask_five_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_req && word_len == 2'b00) |-> ((inj_char >> 5) == '0));

    // R6: a clean single-mode Xoff1 raises the interrupt flag
    p_xoff_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == 2'b10 && rx_err == '0 && rx_char == xoff1 &&
         xoff1 != xon1 && !xon_any) |=> xoff_irq);

    // R8: an errored character always produces a FIFO write
    p_err_written_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_err != '0) |=> rx_wr_en);

    // R11: the halt output holds while a character is on the wire
    p_halt_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> $stable(tx_halt));

endmodule

bind xonxoff_ctrl xonxoff_ctrl_chk #(.CHAR_W(CHAR_W), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/tb_xonxoff_ctrl.sv
module tb_xonxoff_ctrl;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [CW-1:0] rx_char = '0;
    logic [2:0]    rx_err = '0;
    logic [6:0]    rx_level = '0;
    logic          tx_busy = 1'b0;
    logic          inj_ack = 1'b0;
    logic [1:0]    tx_mode = 2'b00;
    logic [1:0]    rx_mode = 2'b00;
    logic          xon_any = 1'b0;
    logic          special_en = 1'b0;
    logic          irq_clr = 1'b0;
    logic [3:0]    halt_thr = 4'd2;
    logic [3:0]    resume_thr = 4'd1;
    logic [1:0]    word_len = 2'b11;
    logic [CW-1:0] xon1 = 8'h11;
    logic [CW-1:0] xon2 = 8'h12;
    logic [CW-1:0] xoff1 = 8'h13;
    logic [CW-1:0] xoff2 = 8'hF4;
    logic          tx_halt, tx_data_en, inj_req, rx_wr_en, xoff_irq;
    logic [CW-1:0] inj_char, rx_wr_char;

    xonxoff_ctrl dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [CW-1:0] wlog [0:4095];
    int wcnt = 0;

    always @(negedge clk) begin
        if (rst_n && rx_wr_en && wcnt < 4096) begin
            wlog[wcnt] = rx_wr_char;
            wcnt++;
        end
    end

    // bench model state
    bit            m_halt = 1'b0;
    bit            m_flag = 1'b0;
    bit            m_held_v = 1'b0;
    bit            m_held_on = 1'b0;
    logic [CW-1:0] m_held_c = '0;
    logic [CW-1:0] e_w [0:1];
    int            e_n = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit is_clean(input logic [2:0] e);
        return (e == 3'b000) && (rx_mode != 2'b00);
    endfunction

    task automatic model_char(input logic [CW-1:0] c, input logic [2:0] e);
        bit cl, used, sq, sg;
        logic [CW-1:0] xs, fs, fx;
        cl = is_clean(e);
        sq = (rx_mode == 2'b11);
        sg = (rx_mode == 2'b10) || (rx_mode == 2'b01);
        xs = (rx_mode == 2'b01) ? xon2 : xon1;
        fs = (rx_mode == 2'b01) ? xoff2 : xoff1;
        fx = sq ? xon1 : xs;
        e_n = 0;
        used = 1'b0;
        if (m_held_v) begin
            m_held_v = 1'b0;
            if (cl && m_held_on && c == xon2) begin
                m_halt = 0; m_flag = 0; used = 1'b1;
            end else if (cl && !m_held_on && c == xoff2) begin
                m_halt = 1; m_flag = 1; used = 1'b1;
            end else begin
                e_w[e_n] = m_held_c; e_n++;
            end
        end
        if (!used) begin
            if (xon_any && m_halt) begin
                m_halt = 0; m_flag = 0;
                if (!(cl && c == fx)) begin e_w[e_n] = c; e_n++; end
            end else if (sq && cl && (c == xon1 || c == xoff1)) begin
                m_held_v = 1'b1; m_held_on = (c == xon1); m_held_c = c;
            end else if (sg && cl && c == xs) begin
                m_halt = 0; m_flag = 0;
            end else if (sg && cl && c == fs) begin
                m_halt = 1; m_flag = 1;
            end else begin
                e_w[e_n] = c; e_n++;
                if (special_en && e == 3'b000 && c == xoff2) m_flag = 1;
            end
        end
    endtask

    task automatic send(input string req, input logic [CW-1:0] c, input logic [2:0] e);
        int w0;
        model_char(c, e);
        w0 = wcnt;
        rx_char = c;
        rx_err = e;
        rx_valid = 1'b1;
        tick(1);
        rx_valid = 1'b0;
        tick(3);
        chk({req, " write count"}, wcnt - w0, e_n);
        for (int k = 0; k < e_n && k < wcnt - w0; k++) begin
            chk({req, " write data"}, wlog[w0 + k], e_w[k]);
        end
        chk({req, " xoff_irq"}, xoff_irq, m_flag);
        if (!tx_busy) chk({req, " tx_halt"}, tx_halt, m_halt);
    endtask

    task automatic set_rx_mode(input logic [1:0] m);
        send("R12 flush", 8'h41, 3'b000);
        rx_mode = m;
        if (m == 2'b00) m_halt = 1'b0;
        tick(2);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        tick(1);
        irq_clr = 1'b0;
        tick(1);
        m_flag = 1'b0;
    endtask

    task automatic take_inj(input string req, input logic [CW-1:0] exp);
        chk({req, " inj_req"}, inj_req, 1'b1);
        chk({req, " inj_char"}, inj_char, exp);
        chk("R3 data blocked", tx_data_en, 1'b0);
        inj_ack = 1'b1;
        tick(1);
        inj_ack = 1'b0;
        tick(3);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R13 reset state
        chk("R13 tx_halt", tx_halt, 1'b0);
        chk("R13 tx_data_en", tx_data_en, 1'b1);
        chk("R13 inj_req", inj_req, 1'b0);
        chk("R13 rx_wr_en", rx_wr_en, 1'b0);
        chk("R13 xoff_irq", xoff_irq, 1'b0);

        // R1 R2: single set 1, halt level 8, resume level 4
        tx_mode = 2'b10;
        rx_level = 7'd8;
        tick(3);
        chk("R2 at halt level no inject", inj_req, 1'b0);
        rx_level = 7'd9;
        tick(3);
        take_inj("R1 xoff1", xoff1);
        chk("R2 single xoff", inj_req, 1'b0);
        rx_level = 7'd5;
        tick(3);
        chk("R2 above resume no xon", inj_req, 1'b0);
        rx_level = 7'd4;
        tick(3);
        take_inj("R2 xon1 at resume", xon1);

        // R3 pairs
        tx_mode = 2'b11;
        rx_level = 7'd9;
        tick(3);
        take_inj("R3 pair first", xoff1);
        take_inj("R3 pair second", xoff2);
        rx_level = 7'd4;
        tick(3);
        take_inj("R3 xon pair first", xon1);
        take_inj("R3 xon pair second", xon2);
        chk("R3 idle after pair", inj_req, 1'b0);

        // R4 word length mask
        tx_mode = 2'b01;
        word_len = 2'b00;
        rx_level = 7'd9;
        tick(3);
        take_inj("R4 five bit xoff2", 8'h14);
        word_len = 2'b10;
        rx_level = 7'd0;
        tick(3);
        take_inj("R4 seven bit xon2", 8'h12);
        word_len = 2'b11;

        // R5 mode change after Xoff
        tx_mode = 2'b10;
        rx_level = 7'd9;
        tick(3);
        take_inj("R5 xoff1 first", xoff1);
        tx_mode = 2'b01;
        tick(3);
        take_inj("R5 original xon1", xon1);
        take_inj("R5 new xoff2", 8'hF4);
        tx_mode = 2'b00;
        tick(3);
        take_inj("R5 disable sends xon2", xon2);
        chk("R5 no xoff when disabled", inj_req, 1'b0);
        rx_level = 7'd0;

        // R11 halt waits for character boundary
        rx_mode = 2'b10;
        tick(2);
        tx_busy = 1'b1;
        send("R6 xoff busy", xoff1, 3'b000);
        chk("R11 halt held while busy", tx_halt, 1'b0);
        tx_busy = 1'b0;
        tick(2);
        chk("R11 halt after boundary", tx_halt, 1'b1);
        chk("R11 data disabled", tx_data_en, 1'b0);
        send("R6 xon releases", xon1, 3'b000);
        send("R8 errored xoff", xoff1, 3'b010);
        rx_mode = 2'b01;
        tick(2);
        send("R6 set2 xoff", 8'hF4, 3'b000);
        send("R6 set2 xon", xon2, 3'b000);

        // R7 sequential
        set_rx_mode(2'b11);
        send("R7 xon1 held", xon1, 3'b000);
        send("R7 broken pair", 8'h41, 3'b000);
        send("R7 xoff1 held", xoff1, 3'b000);
        send("R7 xoff pair", 8'hF4, 3'b000);
        send("R7 xon1 held", xon1, 3'b000);
        send("R7 xon pair", xon2, 3'b000);

        // R9 xon-any
        set_rx_mode(2'b10);
        xon_any = 1'b1;
        send("R9 halt", xoff1, 3'b000);
        send("R9 any char resumes", 8'h42, 3'b000);
        xon_any = 1'b0;

        // R10 special, R12 clear and compare off
        set_rx_mode(2'b00);
        special_en = 1'b1;
        send("R10 special char", 8'hF4, 3'b000);
        clear_irq();
        chk("R12 irq_clr", xoff_irq, 1'b0);
        send("R12 compare off", xoff1, 3'b000);
        special_en = 1'b0;

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [CW-1:0] c;
            logic [2:0] e;
            int r;
            if (i % 25 == 0) begin
                set_rx_mode(2'($urandom % 4));
                xon_any = 1'($urandom % 2);
                special_en = 1'($urandom % 2);
            end
            if ($urandom % 40 == 0) clear_irq();
            r = $urandom % 6;
            case (r)
                0: c = xon1;
                1: c = xon2;
                2: c = xoff1;
                3: c = xoff2;
                default: c = 8'($urandom);
            endcase
            e = ($urandom % 8 == 0) ? 3'(1 + $urandom % 7) : 3'b000;
            send("R7 R8 R9 random", c, e);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule